// File: doc/BRIEF.md
# Count-Down Interrupt Status Unit

This unit holds three 16-bit down-counters: one for playback transfers, one for capture transfers and one general-purpose timer. Playback and capture have their own base registers and enables, so both directions can count at the same time. The transfer counters step on a one-cycle per-sample strobe from the data path. The timer steps on a tick from an internal prescaler that divides the block clock by `TICK_DIV`.

Each counter reloads itself from its base register and keeps running. Each one raises its own sticky flag when its count reaches zero. The flags are ORed into one shared interrupt bit, which drives the level-sensitive `irq_o`. Software clears the flags in one of two ways: it writes 0 to individual flag bits, or it writes any value to the status register, which clears all of them.

The host port is a byte-wide register write port with a combinational read port.

Top module: `cnt_irq_unit`

## Requirements
- R1: After reset, all bases, current counts, enables and flags read 0, and `irq_o` is low.
- R2: Base bytes are written and read back at these addresses: 0/1 playback low/high, 2/3 capture low/high, 4/5 timer low/high. Unmapped addresses read 0.
- R3: Address 6 is the enable register: bit 0 playback, bit 1 capture, bit 2 timer. When an enable bit goes from 0 to 1, the current count is loaded from the base. While an enable bit is 0, that counter's steps are ignored and its count holds. The current counts read at addresses 9/10 (playback), 11/12 (capture) and 13/14 (timer), low byte first.
- R4: On each step, a nonzero count decrements by one and a zero count reloads the base. Playback steps on `play_strobe_i`, capture on `cap_strobe_i`, and the timer on the prescaler tick.
- R5: A step whose result is zero sets that counter's flag in the same clock edge. The flag register is at address 7: bit 0 playback, bit 1 capture, bit 2 timer.
- R6: While the timer is enabled, it steps once every `TICK_DIV` clock cycles. The first step comes `TICK_DIV` cycles after the edge that enabled it.
- R7: Writing 0 to a flag bit clears that flag. Writing 1 to a flag bit has no effect.
- R8: A write of any value to the status register at address 8 clears all flags.
- R9: When a flag's set event and a clear of that flag fall in the same cycle, the flag ends up set.
- R10: `irq_o` and status bit 0 are high exactly when at least one flag is set.
- R11: Each counter steps only on its own source. Activity on one counter leaves the others' counts unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register address for read and write |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Combinational read data at addr_i |
| play_strobe_i | input | 1 | Playback sample strobe |
| cap_strobe_i | input | 1 | Capture sample strobe |
| irq_o | output | 1 | Shared interrupt, level |

## Verification
The hardest case to reach is a flag clear that lands in the very cycle the timer count reaches zero. Reaching it needs cycle-exact knowledge of the prescaler phase.

The bench enables the timer with a small base and tracks the tick phase from the enabling edge. It clears the flag once, waits exactly to the edge where the count hits zero again, and issues the clear write on that edge. The flag must then still read set.

Disabled-counter strobes and write-one-to-flag writes are checked by reading the counts and flags back afterwards.

// File: rtl/cnt_irq_pkg.sv
package cnt_irq_pkg;
  localparam int CNT_W = 16;
  localparam int NCH   = 3;
  localparam int CH_PLAY = 0;
  localparam int CH_CAP  = 1;
  localparam int CH_TMR  = 2;

  localparam logic [3:0] A_CTRL   = 4'd6;
  localparam logic [3:0] A_FLAGS  = 4'd7;
  localparam logic [3:0] A_STATUS = 4'd8;
  localparam logic [3:0] A_CUR0   = 4'd9;

  typedef logic [CNT_W-1:0] cnt_t;
endpackage

// File: rtl/cnt_prescaler.sv
module cnt_prescaler #(
  parameter int DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            div_q <= '0;
    else if (!en_i)         div_q <= '0;
    else if (div_q == LAST) div_q <= '0;
    else                    div_q <= div_q + 1'b1;
  end

  assign tick_o = en_i && (div_q == LAST);

  a_r6_tick_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/cnt_down_ctr.sv
module cnt_down_ctr
  import cnt_irq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic load_i,
  input  logic step_i,
  input  cnt_t base_i,
  output cnt_t cnt_o,
  output logic evt_o
);
  cnt_t cnt_q, cnt_nxt;
  logic adv;

  assign adv     = en_i && step_i && !load_i;
  assign cnt_nxt = (cnt_q == '0) ? base_i : cnt_q - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= base_i;
    else if (adv)    cnt_q <= cnt_nxt;
  end

  assign evt_o = adv && (cnt_nxt == '0);
  assign cnt_o = cnt_q;

  a_r3_hold_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !load_i) |=> $stable(cnt_q));
  a_r3_load_base: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == $past(base_i));
  a_r4_reload_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && step_i && !load_i && cnt_q == '0) |=> cnt_q == $past(base_i));
endmodule

// File: rtl/cnt_irq_flags.sv
module cnt_irq_flags #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] evt_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flags_o,
  output logic         irq_o
);
  logic [N-1:0] flags_q;

  for (genvar k = 0; k < N; k++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flags_q[k] <= 1'b0;
      else if (evt_i[k]) flags_q[k] <= 1'b1;  // set beats clear
      else if (clr_i[k]) flags_q[k] <= 1'b0;
    end

    a_r9_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_i[k] |=> flags_q[k]);
    a_r7_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[k] && !evt_i[k]) |=> !flags_q[k]);
  end

  assign flags_o = flags_q;
  assign irq_o   = |flags_q;
endmodule

// File: rtl/cnt_irq_unit.sv
module cnt_irq_unit
  import cnt_irq_pkg::*;
#(
  parameter int TICK_DIV = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [3:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic       play_strobe_i,
  input  logic       cap_strobe_i,
  output logic       irq_o
);
  cnt_t           base_q [NCH];
  cnt_t           cur    [NCH];
  logic [NCH-1:0] ctrl_q, load, step, evt, clr, flags;
  logic           tick;

  // base bytes and enables
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int c = 0; c < NCH; c++) base_q[c] <= '0;
      ctrl_q <= '0;
    end else if (wr_i) begin
      for (int c = 0; c < NCH; c++) begin
        if (addr_i == 4'(2*c))   base_q[c][7:0]  <= wdata_i;
        if (addr_i == 4'(2*c+1)) base_q[c][15:8] <= wdata_i;
      end
      if (addr_i == A_CTRL) ctrl_q <= wdata_i[NCH-1:0];
    end
  end

  assign load = (wr_i && addr_i == A_CTRL) ? (wdata_i[NCH-1:0] & ~ctrl_q) : '0;

  always_comb begin
    clr = '0;
    if (wr_i && addr_i == A_FLAGS)  clr = ~wdata_i[NCH-1:0];
    if (wr_i && addr_i == A_STATUS) clr = '1;
  end

  cnt_prescaler #(.DIV(TICK_DIV)) u_presc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (ctrl_q[CH_TMR]),
    .tick_o(tick)
  );

  assign step[CH_PLAY] = play_strobe_i;
  assign step[CH_CAP]  = cap_strobe_i;
  assign step[CH_TMR]  = tick;

  for (genvar c = 0; c < NCH; c++) begin : g_ctr
    cnt_down_ctr u_ctr (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .en_i  (ctrl_q[c]),
      .load_i(load[c]),
      .step_i(step[c]),
      .base_i(base_q[c]),
      .cnt_o (cur[c]),
      .evt_o (evt[c])
    );
  end

  cnt_irq_flags #(.N(NCH)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (evt),
    .clr_i  (clr),
    .flags_o(flags),
    .irq_o  (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    for (int c = 0; c < NCH; c++) begin
      if (addr_i == 4'(2*c))            rdata_o = base_q[c][7:0];
      if (addr_i == 4'(2*c+1))          rdata_o = base_q[c][15:8];
      if (addr_i == A_CUR0 + 4'(2*c))   rdata_o = cur[c][7:0];
      if (addr_i == A_CUR0 + 4'(2*c+1)) rdata_o = cur[c][15:8];
    end
    if (addr_i == A_CTRL)   rdata_o = 8'(ctrl_q);
    if (addr_i == A_FLAGS)  rdata_o = 8'(flags);
    if (addr_i == A_STATUS) rdata_o = {7'd0, irq_o};
  end

  a_r8_status_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == A_STATUS && evt == '0) |=> !irq_o);
  a_r3_single_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|load) |=> ((ctrl_q & $past(load)) == $past(load)));
endmodule

// File: tb/cnt_irq_unit_tb.sv
`timescale 1ns/100ps
module cnt_irq_unit_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       ps = 1'b0, cs = 1'b0;
  logic       irq;
  int         n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;  // 250 MHz

  cnt_irq_unit #(.TICK_DIV(4)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .play_strobe_i(ps), .cap_strobe_i(cs), .irq_o(irq)
  );

  // {op, addr, data, expect, req}; op 0 write, 1 read-compare, 2 play strobes, 3 capture strobes
  localparam int NV = 42;
  localparam logic [25:0] VEC [NV] = '{
    {2'd1, 4'd8,  8'h00, 8'h00, 4'd1},  // R1 status
    {2'd1, 4'd0,  8'h00, 8'h00, 4'd1},  // R1 base
    {2'd0, 4'd0,  8'h03, 8'h00, 4'd2},
    {2'd0, 4'd1,  8'h00, 8'h00, 4'd2},
    {2'd1, 4'd0,  8'h00, 8'h03, 4'd2},  // R2
    {2'd0, 4'd6,  8'h01, 8'h00, 4'd3},
    {2'd1, 4'd9,  8'h00, 8'h03, 4'd3},  // R3 load
    {2'd2, 4'd0,  8'd2,  8'h00, 4'd4},
    {2'd1, 4'd9,  8'h00, 8'h01, 4'd4},  // R4 decrement
    {2'd1, 4'd7,  8'h00, 8'h00, 4'd5},
    {2'd2, 4'd0,  8'd1,  8'h00, 4'd5},
    {2'd1, 4'd7,  8'h00, 8'h01, 4'd5},  // R5 flag at zero
    {2'd1, 4'd8,  8'h00, 8'h01, 4'd10}, // R10
    {2'd2, 4'd0,  8'd1,  8'h00, 4'd4},
    {2'd1, 4'd9,  8'h00, 8'h03, 4'd4},  // R4 reload
    {2'd0, 4'd7,  8'hFF, 8'h00, 4'd7},
    {2'd1, 4'd7,  8'h00, 8'h01, 4'd7},  // R7 write 1 no effect
    {2'd0, 4'd7,  8'hFE, 8'h00, 4'd7},
    {2'd1, 4'd7,  8'h00, 8'h00, 4'd7},  // R7 clear
    {2'd1, 4'd8,  8'h00, 8'h00, 4'd10}, // R10
    {2'd3, 4'd0,  8'd5,  8'h00, 4'd3},
    {2'd1, 4'd11, 8'h00, 8'h00, 4'd3},  // R3 disabled ignores strobes
    {2'd0, 4'd2,  8'h01, 8'h00, 4'd2},
    {2'd0, 4'd3,  8'h01, 8'h00, 4'd2},
    {2'd1, 4'd3,  8'h00, 8'h01, 4'd2},  // R2
    {2'd0, 4'd6,  8'h03, 8'h00, 4'd3},
    {2'd1, 4'd11, 8'h00, 8'h01, 4'd3},  // R3
    {2'd1, 4'd12, 8'h00, 8'h01, 4'd3},
    {2'd3, 4'd0,  8'd1,  8'h00, 4'd11},
    {2'd1, 4'd11, 8'h00, 8'h00, 4'd11}, // R11
    {2'd1, 4'd12, 8'h00, 8'h01, 4'd11},
    {2'd1, 4'd9,  8'h00, 8'h03, 4'd11}, // R11 playback untouched
    {2'd2, 4'd0,  8'd3,  8'h00, 4'd5},
    {2'd1, 4'd7,  8'h00, 8'h01, 4'd5},
    {2'd1, 4'd12, 8'h00, 8'h01, 4'd11},
    {2'd0, 4'd8,  8'h00, 8'h00, 4'd8},
    {2'd1, 4'd7,  8'h00, 8'h00, 4'd8},  // R8
    {2'd1, 4'd8,  8'h00, 8'h00, 4'd8},
    {2'd0, 4'd6,  8'h00, 8'h00, 4'd3},
    {2'd2, 4'd0,  8'd4,  8'h00, 4'd3},
    {2'd1, 4'd9,  8'h00, 8'h00, 4'd3},  // R3 hold while off
    {2'd1, 4'd7,  8'h00, 8'h00, 4'd3}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(posedge clk); @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a, input logic [7:0] exp);
    addr = a; #0.2;
    chk(req, rdata, exp);
  endtask

  task automatic strobe(input bit cap, input int n);
    if (cap) cs = 1'b1; else ps = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
    end
    cs = 1'b0; ps = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 irq", {7'd0, irq}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] op;
      logic [3:0] a;
      logic [7:0] d, e;
      string      tag;
      {op, a, d, e} = VEC[i][25:4];
      tag = $sformatf("R%0d vec%0d", VEC[i][3:0], i);
      case (op)
        2'd0: wr_reg(a, d);
        2'd1: rd_chk(tag, a, e);
        2'd2: strobe(1'b0, int'(d));
        default: strobe(1'b1, int'(d));
      endcase
    end

    // timer: base 2, prescaler 4, enable edge E0
    wr_reg(4'd4, 8'd2);
    wr_reg(4'd5, 8'd0);
    wr_reg(4'd6, 8'h04);
    repeat (7) @(negedge clk);                 // after E7
    rd_chk("R6 count before second tick", 4'd13, 8'd1);
    rd_chk("R6 no flag yet", 4'd7, 8'h00);
    @(negedge clk);                            // after E8
    rd_chk("R5 timer flag", 4'd7, 8'h04);
    chk("R10 irq high", {7'd0, irq}, 8'h01);
    repeat (4) @(negedge clk);                 // after E12
    rd_chk("R4 timer reload", 4'd13, 8'd2);
    rd_chk("R4 timer high", 4'd14, 8'd0);
    wr_reg(4'd7, 8'h00);                       // E13
    rd_chk("R7 timer flag cleared", 4'd7, 8'h00);
    chk("R10 irq low", {7'd0, irq}, 8'h00);
    repeat (6) @(negedge clk);                 // after E19
    wr_reg(4'd7, 8'h00);                       // E20 meets zero event
    rd_chk("R9 set beats clear", 4'd7, 8'h04);
    chk("R9 irq", {7'd0, irq}, 8'h01);
    wr_reg(4'd8, 8'h5A);
    rd_chk("R8 status clears timer", 4'd7, 8'h00);
    chk("R8 irq low", {7'd0, irq}, 8'h00);
    rd_chk("R2 unmapped", 4'd15, 8'h00);

    finish_run();
  end
endmodule